// File: doc/BRIEF.md
# Sacrificial-Line Chunk Repair Read/Write Path

This block is the data path of a two-bank cache array that must keep working when a low supply voltage leaves some storage chunks unreliable. Each line is cut into equal chunks. Lines are gathered into repair groups: one line of a group stores no data of its own and lends its chunks to the other members, and each member of a group is known by a small member number. A request index first looks up a per-index map entry. That entry names the physical line that holds the data, the group's spare line in the other bank, the requester's member number and the group. Both lines are read in the same cycle. A per-group slot table records which member owns each spare chunk. Per-chunk comparators then decide, chunk by chunk, whether the spare line or the data line supplies the result.

In full-voltage operation the map and the chunk selection are bypassed: the request index is the physical line itself and every line is usable. Writes in low-voltage operation use the same ownership information in reverse. The data line takes the whole word, and only the spare chunks owned by the writer are updated. The map and slot table are loaded through a configuration port, normally once at start-up from a stored repair plan.

Top module: `sacline_repair_path`

## Requirements
- R1: With `low_pwr`=0, a read of index I returns physical line I (most significant index bit = bank, remaining bits = row) unmodified, with `rsp_valid` high exactly 1 cycle after the request.
- R2: With `low_pwr`=0, every physical line can be written and read, including lines that the low-voltage map marks as spare or disabled, and no response carries `rsp_err`.
- R3: With `low_pwr`=1, the request index selects a map entry whose data line and spare line are read together. A valid entry always places the spare line in the bank opposite the data line (their most significant bits differ).
- R4: A slot-table entry holds one member number per chunk, with chunk k's slot at bits [k*GA_W +: GA_W]. The all-ones value means the chunk is unowned, and no map entry of kind data uses the all-ones member number.
- R5: In a low-voltage read, chunk k (bits [k*CHUNK_W +: CHUNK_W]) comes from the spare line when slot k equals the requester's member number, and from the data line otherwise.
- R6: In low-voltage operation a response appears exactly 1+LP_LAT cycles after its request (3 with the default LP_LAT=2), and back-to-back requests keep their order.
- R7: A low-voltage access to an index whose map kind is not data (kind 1 = spare, kind 2 = disabled, kind 3 = disabled) returns `rsp_err`=1 with all-zero data and leaves both banks unchanged.
- R8: A low-voltage write stores the full word into the data line, and writes chunk k of the word into the spare line only where slot k equals the writer's member number. Other spare chunks keep their contents. Every write response carries zero data.
- R9: Map entries reset to kind 2 (disabled) and slot entries reset to all-ones. A change of `low_pwr` made while no access is in flight governs the next request.
- R10: During and just after reset, `rsp_valid` and `rsp_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| low_pwr | input | 1 | 1 = low-voltage mode (map and chunk selection active), 0 = bypass |
| cfg_map_we | input | 1 | Write one map entry |
| cfg_map_idx | input | ROW_W+1 | Map entry index |
| cfg_map_kind | input | 2 | Entry kind: 0 data, 1 spare, 2 disabled |
| cfg_map_line | input | ROW_W+1 | Physical data line {bank, row} |
| cfg_map_sac | input | ROW_W+1 | Physical spare line {bank, row} |
| cfg_map_gaddr | input | GA_W | Member number within the group |
| cfg_map_grp | input | GRP_W | Group number (slot-table row) |
| cfg_fm_we | input | 1 | Write one slot-table entry |
| cfg_fm_grp | input | GRP_W | Slot-table row |
| cfg_fm_slots | input | CHUNKS*GA_W | Owner member number per spare chunk |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | ROW_W+1 | Request index |
| req_wdata | input | CHUNKS*CHUNK_W | Write word |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Access hit a non-data map entry |
| rsp_rdata | output | CHUNKS*CHUNK_W | Read word (zero for writes and errors) |

## Verification
Lines are preloaded in bypass mode with a pattern that gives every chunk of every line a distinct value, so a byte taken from the wrong line or the wrong chunk position is visible at once. Low-voltage reads then cover members whose owned spare chunks sit at the low end, the high end, the middle and at two adjacent positions, plus a member whose data line differs from its index. This separates a slot compare against the wrong member from a chunk that is misplaced or taken from the wrong bank. Writes in low-voltage mode are followed by reads through both modes, which shows whether spare chunks owned by other members were disturbed. Accesses to spare, disabled and never-configured indices show whether the error path both blanks the data and suppresses the write.

// File: rtl/srp_pkg.sv
package srp_pkg;
   typedef enum logic [1:0] {
      KIND_DATA = 2'd0,
      KIND_SACR = 2'd1,
      KIND_OFF  = 2'd2
   } srp_kind_e;
endpackage

// File: rtl/srp_mem_map.sv
module srp_mem_map
   import srp_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4,
   parameter int GA_W    = 2,
   parameter int GRP_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [1:0]       wkind,
   input  logic [IDX_W-1:0] wline,
   input  logic [IDX_W-1:0] wsac,
   input  logic [GA_W-1:0]  wgaddr,
   input  logic [GRP_W-1:0] wgrp,
   input  logic [IDX_W-1:0] ridx,
   output logic [1:0]       rkind,
   output logic [IDX_W-1:0] rline,
   output logic [IDX_W-1:0] rsac,
   output logic [GA_W-1:0]  rgaddr,
   output logic [GRP_W-1:0] rgrp
);
   logic [1:0]       kind_q  [ENTRIES];
   logic [IDX_W-1:0] line_q  [ENTRIES];
   logic [IDX_W-1:0] sac_q   [ENTRIES];
   logic [GA_W-1:0]  gaddr_q [ENTRIES];
   logic [GRP_W-1:0] grp_q   [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            kind_q[i]  <= KIND_OFF;
            line_q[i]  <= '0;
            sac_q[i]   <= '0;
            gaddr_q[i] <= '0;
            grp_q[i]   <= '0;
         end
      end else if (we) begin
         kind_q[widx]  <= wkind;
         line_q[widx]  <= wline;
         sac_q[widx]   <= wsac;
         gaddr_q[widx] <= wgaddr;
         grp_q[widx]   <= wgrp;
      end
   end

   assign rkind  = kind_q[ridx];
   assign rline  = line_q[ridx];
   assign rsac   = sac_q[ridx];
   assign rgaddr = gaddr_q[ridx];
   assign rgrp   = grp_q[ridx];
endmodule

// File: rtl/srp_fault_map.sv
module srp_fault_map #(
   parameter int GROUPS = 4,
   parameter int GRP_W  = 2,
   parameter int CHUNKS = 4,
   parameter int GA_W   = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [GRP_W-1:0]       wgrp,
   input  logic [CHUNKS*GA_W-1:0] wslots,
   input  logic [GRP_W-1:0]       rgrp,
   input  logic [GA_W-1:0]        gaddr,
   output logic [CHUNKS-1:0]      take_spare
);
   localparam int SLOT_W = CHUNKS * GA_W;
   localparam logic [GA_W-1:0] NO_OWNER = {GA_W{1'b1}};

   logic [SLOT_W-1:0] slots_q [GROUPS];
   logic [SLOT_W-1:0] row;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < GROUPS; i++) slots_q[i] <= '1;
      end else if (we) begin
         slots_q[wgrp] <= wslots;
      end
   end

   assign row = slots_q[rgrp];

   for (genvar k = 0; k < CHUNKS; k++) begin : g_cmp
      assign take_spare[k] = (row[k*GA_W +: GA_W] == gaddr) && (gaddr != NO_OWNER);
   end
endmodule

// File: rtl/srp_chunk_mux.sv
module srp_chunk_mux #(
   parameter int CHUNKS  = 4,
   parameter int CHUNK_W = 8
) (
   input  logic [CHUNKS*CHUNK_W-1:0] data_line,
   input  logic [CHUNKS*CHUNK_W-1:0] spare_line,
   input  logic [CHUNKS-1:0]         take_spare,
   output logic [CHUNKS*CHUNK_W-1:0] merged
);
   for (genvar k = 0; k < CHUNKS; k++) begin : g_chunk
      assign merged[k*CHUNK_W +: CHUNK_W] = take_spare[k] ? spare_line[k*CHUNK_W +: CHUNK_W]
                                                          : data_line[k*CHUNK_W +: CHUNK_W];
   end
endmodule

// File: rtl/srp_lat_pipe.sv
module srp_lat_pipe #(
   parameter int DEPTH = 3,
   parameter int W     = 33
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         head_v,
   input  logic         tail_v,
   input  logic [W-1:0] in_pay,
   output logic         out_v,
   output logic [W-1:0] out_pay
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_st
      logic         v;
      logic [W-1:0] p;
      logic         nv;
      logic [W-1:0] np;

      if (i == 0) begin : g_head
         assign nv = head_v;
         assign np = in_pay;
      end else if (i == DEPTH - 1) begin : g_tail
         assign nv = g_st[i-1].v | tail_v;
         assign np = tail_v ? in_pay : g_st[i-1].p;
      end else begin : g_mid
         assign nv = g_st[i-1].v;
         assign np = g_st[i-1].p;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v <= 1'b0;
            p <= '0;
         end else begin
            v <= nv;
            p <= nv ? np : '0;
         end
      end
   end

   assign out_v   = g_st[DEPTH-1].v;
   assign out_pay = g_st[DEPTH-1].p;
endmodule

// File: rtl/sacline_repair_path.sv
module sacline_repair_path
   import srp_pkg::*;
#(
   parameter int CHUNKS  = 4,
   parameter int CHUNK_W = 8,
   parameter int ROWS    = 8,
   parameter int GA_W    = 2,
   parameter int GROUPS  = 4,
   parameter int LP_LAT  = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          low_pwr,
   input  logic                          cfg_map_we,
   input  logic [$clog2(ROWS):0]         cfg_map_idx,
   input  logic [1:0]                    cfg_map_kind,
   input  logic [$clog2(ROWS):0]         cfg_map_line,
   input  logic [$clog2(ROWS):0]         cfg_map_sac,
   input  logic [GA_W-1:0]               cfg_map_gaddr,
   input  logic [$clog2(GROUPS)-1:0]     cfg_map_grp,
   input  logic                          cfg_fm_we,
   input  logic [$clog2(GROUPS)-1:0]     cfg_fm_grp,
   input  logic [CHUNKS*GA_W-1:0]        cfg_fm_slots,
   input  logic                          req_valid,
   input  logic                          req_write,
   input  logic [$clog2(ROWS):0]         req_idx,
   input  logic [CHUNKS*CHUNK_W-1:0]     req_wdata,
   output logic                          rsp_valid,
   output logic                          rsp_err,
   output logic [CHUNKS*CHUNK_W-1:0]     rsp_rdata
);
   localparam int LINE_W = CHUNKS * CHUNK_W;
   localparam int ROW_W  = $clog2(ROWS);
   localparam int PL_W   = ROW_W + 1;
   localparam int GRP_W  = $clog2(GROUPS);
   localparam int DEPTH  = LP_LAT + 1;

   if (LP_LAT < 1 || LP_LAT > 2) begin : g_bad_lat
      $error("LP_LAT must be 1 or 2");
   end
   if (ROWS < 2 || (1 << ROW_W) != ROWS) begin : g_bad_rows
      $error("ROWS must be a power of two of at least 2");
   end
   if (GROUPS < 2 || GA_W < 1 || CHUNKS < 1 || CHUNK_W < 1) begin : g_bad_size
      $error("GROUPS >= 2, GA_W, CHUNKS and CHUNK_W >= 1 required");
   end

   logic [1:0]       m_kind;
   logic [PL_W-1:0]  m_line, m_sac;
   logic [GA_W-1:0]  m_gaddr;
   logic [GRP_W-1:0] m_grp;
   logic [CHUNKS-1:0] take_spare;

   srp_mem_map #(.ENTRIES(2*ROWS), .IDX_W(PL_W), .GA_W(GA_W), .GRP_W(GRP_W)) u_map (
      .clk(clk), .rst_n(rst_n),
      .we(cfg_map_we), .widx(cfg_map_idx), .wkind(cfg_map_kind), .wline(cfg_map_line),
      .wsac(cfg_map_sac), .wgaddr(cfg_map_gaddr), .wgrp(cfg_map_grp),
      .ridx(req_idx), .rkind(m_kind), .rline(m_line), .rsac(m_sac),
      .rgaddr(m_gaddr), .rgrp(m_grp)
   );

   srp_fault_map #(.GROUPS(GROUPS), .GRP_W(GRP_W), .CHUNKS(CHUNKS), .GA_W(GA_W)) u_fmap (
      .clk(clk), .rst_n(rst_n),
      .we(cfg_fm_we), .wgrp(cfg_fm_grp), .wslots(cfg_fm_slots),
      .rgrp(m_grp), .gaddr(m_gaddr), .take_spare(take_spare)
   );

   logic [PL_W-1:0]  act_line;
   logic             dbank;
   logic [ROW_W-1:0] drow, srow;
   logic             lp_ok, wr_go;
   logic             bank_we   [2];
   logic [CHUNKS-1:0] bank_mask [2];
   logic [ROW_W-1:0] bank_row  [2];
   logic [LINE_W-1:0] bank_rd  [2];

   assign act_line = low_pwr ? m_line : req_idx;
   assign dbank    = act_line[PL_W-1];
   assign drow     = act_line[ROW_W-1:0];
   assign srow     = m_sac[ROW_W-1:0];
   assign lp_ok    = (m_kind == KIND_DATA);
   assign wr_go    = req_valid && req_write && (!low_pwr || lp_ok);

   always_comb begin
      for (int b = 0; b < 2; b++) begin
         if (b[0] == dbank) begin
            bank_row[b]  = drow;
            bank_mask[b] = '1;
            bank_we[b]   = wr_go;
         end else begin
            bank_row[b]  = srow;
            bank_mask[b] = low_pwr ? take_spare : '0;
            bank_we[b]   = wr_go && low_pwr;
         end
      end
   end

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [LINE_W-1:0] mem [ROWS];
      always_ff @(posedge clk) begin
         if (bank_we[b]) begin
            for (int k = 0; k < CHUNKS; k++) begin
               if (bank_mask[b][k]) mem[bank_row[b]][k*CHUNK_W +: CHUNK_W] <= req_wdata[k*CHUNK_W +: CHUNK_W];
            end
         end
      end
      assign bank_rd[b] = mem[bank_row[b]];
   end

   logic [LINE_W-1:0] dline, sline, merged, rd_val;
   logic              pay_err;
   logic [LINE_W-1:0] pay_data;

   assign dline = bank_rd[dbank];
   assign sline = bank_rd[m_sac[PL_W-1]];

   srp_chunk_mux #(.CHUNKS(CHUNKS), .CHUNK_W(CHUNK_W)) u_mux (
      .data_line(dline), .spare_line(sline), .take_spare(take_spare), .merged(merged)
   );

   assign rd_val   = low_pwr ? merged : dline;
   assign pay_err  = low_pwr && !lp_ok;
   assign pay_data = (req_write || pay_err) ? '0 : rd_val;

   srp_lat_pipe #(.DEPTH(DEPTH), .W(LINE_W + 1)) u_pipe (
      .clk(clk), .rst_n(rst_n),
      .head_v(req_valid && low_pwr), .tail_v(req_valid && !low_pwr),
      .in_pay({pay_err, pay_data}),
      .out_v(rsp_valid), .out_pay({rsp_err, rsp_rdata})
   );
endmodule

// File: rtl/srp_checker.sv
module srp_checker
   import srp_pkg::*;
#(
   parameter int LINE_W = 32,
   parameter int PL_W   = 4,
   parameter int GA_W   = 2,
   parameter int LP_LAT = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              low_pwr,
   input logic              req_valid,
   input logic              cfg_map_we,
   input logic [1:0]        cfg_map_kind,
   input logic [PL_W-1:0]   cfg_map_line,
   input logic [PL_W-1:0]   cfg_map_sac,
   input logic [GA_W-1:0]   cfg_map_gaddr,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [LINE_W-1:0] rsp_rdata
);
   assert_bypass_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!low_pwr && req_valid) |=> rsp_valid);

   assert_err_only_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> low_pwr);

   assert_spare_opposite_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_map_we && cfg_map_kind == KIND_DATA) |-> (cfg_map_line[PL_W-1] != cfg_map_sac[PL_W-1]));

   assert_member_not_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_map_we && cfg_map_kind == KIND_DATA) |-> (cfg_map_gaddr != {GA_W{1'b1}}));

   assert_low_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (low_pwr && rsp_valid) |-> $past(req_valid, LP_LAT + 1));

   assert_err_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == '0));

   assert_idle_after_reset_R10: assert property (@(posedge clk)
      !rst_n |=> (!rsp_valid && !rsp_err));
endmodule

bind sacline_repair_path srp_checker #(
   .LINE_W(CHUNKS*CHUNK_W), .PL_W($clog2(ROWS)+1), .GA_W(GA_W), .LP_LAT(LP_LAT)
) u_srp_chk (
   .clk(clk), .rst_n(rst_n), .low_pwr(low_pwr), .req_valid(req_valid),
   .cfg_map_we(cfg_map_we), .cfg_map_kind(cfg_map_kind), .cfg_map_line(cfg_map_line),
   .cfg_map_sac(cfg_map_sac), .cfg_map_gaddr(cfg_map_gaddr),
   .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/tb_sacline_repair_path.sv
`timescale 1ns/1ps
module tb_sacline_repair_path;
   localparam int LPL = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        low_pwr;
   logic        cfg_map_we;
   logic [3:0]  cfg_map_idx, cfg_map_line, cfg_map_sac;
   logic [1:0]  cfg_map_kind, cfg_map_gaddr, cfg_map_grp;
   logic        cfg_fm_we;
   logic [1:0]  cfg_fm_grp;
   logic [7:0]  cfg_fm_slots;
   logic        req_valid, req_write;
   logic [3:0]  req_idx;
   logic [31:0] req_wdata;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;

   sacline_repair_path #(.CHUNKS(4), .CHUNK_W(8), .ROWS(8), .GA_W(2), .GROUPS(4), .LP_LAT(LPL)) dut (
      .clk(clk), .rst_n(rst_n), .low_pwr(low_pwr),
      .cfg_map_we(cfg_map_we), .cfg_map_idx(cfg_map_idx), .cfg_map_kind(cfg_map_kind),
      .cfg_map_line(cfg_map_line), .cfg_map_sac(cfg_map_sac), .cfg_map_gaddr(cfg_map_gaddr),
      .cfg_map_grp(cfg_map_grp), .cfg_fm_we(cfg_fm_we), .cfg_fm_grp(cfg_fm_grp),
      .cfg_fm_slots(cfg_fm_slots), .req_valid(req_valid), .req_write(req_write),
      .req_idx(req_idx), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
   );

   always #4 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] q_d [$];
   logic        q_e [$];
   int          q_c [$];
   string       q_t [$];

   function automatic logic [31:0] pat(int l);
      return {8'(l*16+3), 8'(l*16+2), 8'(l*16+1), 8'(l*16)};
   endfunction

   task automatic issue(input bit wr, input logic [3:0] idx, input logic [31:0] wd,
                        input logic [31:0] exp_d, input bit exp_e, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_idx = idx; req_wdata = wd;
      q_d.push_back(exp_d); q_e.push_back(exp_e);
      q_c.push_back(cyc + (low_pwr ? LPL + 1 : 1)); q_t.push_back(tag);
   endtask

   task automatic settle();
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      for (int i = 0; i < 10 && q_d.size() > 0; i++) @(negedge clk);
      if (q_d.size() != 0) begin
         checks++; errors++;
         $display("FAIL %s: missing response, got none expected %0d pending", q_t[0], q_d.size());
         q_d.delete(); q_e.delete(); q_c.delete(); q_t.delete();
      end
   endtask

   task automatic map_set(input logic [3:0] idx, input logic [1:0] kind, input logic [3:0] line,
                          input logic [3:0] sac, input logic [1:0] ga, input logic [1:0] grp);
      @(negedge clk);
      cfg_map_we = 1'b1; cfg_map_idx = idx; cfg_map_kind = kind; cfg_map_line = line;
      cfg_map_sac = sac; cfg_map_gaddr = ga; cfg_map_grp = grp;
      @(negedge clk);
      cfg_map_we = 1'b0;
   endtask

   task automatic slots_set(input logic [1:0] grp, input logic [7:0] slots);
      @(negedge clk);
      cfg_fm_we = 1'b1; cfg_fm_grp = grp; cfg_fm_slots = slots;
      @(negedge clk);
      cfg_fm_we = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         checks++;
         if (q_d.size() == 0) begin
            errors++;
            $display("FAIL R6: unexpected response data=%h err=%0b expected none", rsp_rdata, rsp_err);
         end else begin
            logic [31:0] d; logic e; int c; string t;
            d = q_d.pop_front(); e = q_e.pop_front(); c = q_c.pop_front(); t = q_t.pop_front();
            if (rsp_rdata !== d || rsp_err !== e || cyc != c) begin
               errors++;
               $display("FAIL %s: got data=%h err=%0b cycle=%0d expected data=%h err=%0b cycle=%0d",
                        t, rsp_rdata, rsp_err, cyc, d, e, c);
            end
         end
      end
   end

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got no end by cycle %0d expected end earlier", cyc);
         summary();
         $finish;
      end
   end

   localparam logic [31:0] WV = 32'hA1B2C3D4;

   initial begin
      rst_n = 1'b0; low_pwr = 1'b0;
      cfg_map_we = 0; cfg_map_idx = 0; cfg_map_kind = 0; cfg_map_line = 0; cfg_map_sac = 0;
      cfg_map_gaddr = 0; cfg_map_grp = 0; cfg_fm_we = 0; cfg_fm_grp = 0; cfg_fm_slots = 0;
      req_valid = 0; req_write = 0; req_idx = 0; req_wdata = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || rsp_err !== 1'b0) begin
         errors++;
         $display("FAIL R10: got valid=%0b err=%0b expected valid=0 err=0", rsp_valid, rsp_err);
      end

      // R9: map starts disabled; mode change governs the next request
      low_pwr = 1'b1;
      issue(0, 4'd6, 0, 32'h0, 1'b1, "R9 reset map kind disabled");
      settle();
      low_pwr = 1'b0;

      // R2: fill every physical line in bypass mode, back to back
      for (int l = 0; l < 16; l++) issue(1, 4'(l), pat(l), 32'h0, 1'b0, "R2 bypass write");
      settle();
      issue(0, 4'd0,  0, pat(0),  1'b0, "R1 bypass read line 0");
      issue(0, 4'd9,  0, pat(9),  1'b0, "R1 bypass read line 9");
      issue(0, 4'd15, 0, pat(15), 1'b0, "R1 bypass read line 15");
      settle();

      // group 0: spare line 0; group 1: spare line 10
      map_set(4'd9,  2'd0, 4'd9,  4'd0,  2'd1, 2'd0);
      map_set(4'd11, 2'd0, 4'd11, 4'd0,  2'd2, 2'd0);
      map_set(4'd4,  2'd0, 4'd12, 4'd0,  2'd0, 2'd0);
      map_set(4'd0,  2'd1, 4'd0,  4'd0,  2'd0, 2'd0);
      map_set(4'd2,  2'd0, 4'd2,  4'd10, 2'd0, 2'd1);
      map_set(4'd3,  2'd0, 4'd3,  4'd10, 2'd1, 2'd1);
      map_set(4'd10, 2'd1, 4'd10, 4'd0,  2'd0, 2'd0);
      map_set(4'd15, 2'd2, 4'd15, 4'd0,  2'd0, 2'd0);
      slots_set(2'd0, {2'd2, 2'd3, 2'd0, 2'd1});
      slots_set(2'd1, {2'd3, 2'd1, 2'd1, 2'd0});

      low_pwr = 1'b1;
      issue(0, 4'd9,  0, {pat(9)[31:8], pat(0)[7:0]},  1'b0, "R5 chunk 0 from spare");
      issue(0, 4'd11, 0, {pat(0)[31:24], pat(11)[23:0]}, 1'b0, "R5 chunk 3 from spare");
      issue(0, 4'd4,  0, {pat(12)[31:16], pat(0)[15:8], pat(12)[7:0]}, 1'b0, "R3 remapped data line R5");
      issue(0, 4'd2,  0, {pat(2)[31:8], pat(10)[7:0]}, 1'b0, "R3 spare in bank 1 R6 back to back");
      issue(0, 4'd3,  0, {pat(3)[31:24], pat(10)[23:8], pat(3)[7:0]}, 1'b0, "R5 two adjacent spare chunks");
      settle();

      issue(0, 4'd0,  0, 32'h0, 1'b1, "R7 spare index read");
      issue(0, 4'd15, 0, 32'h0, 1'b1, "R7 disabled index read");
      issue(0, 4'd10, 0, 32'h0, 1'b1, "R7 spare index bank 1");
      settle();

      issue(1, 4'd9, WV, 32'h0, 1'b0, "R8 low-voltage write");
      issue(1, 4'd0, 32'hFFFF_FFFF, 32'h0, 1'b1, "R7 write to spare index");
      settle();
      issue(0, 4'd9,  0, WV, 1'b0, "R8 read back written member");
      issue(0, 4'd4,  0, {pat(12)[31:16], pat(0)[15:8], pat(12)[7:0]}, 1'b0, "R8 other member chunk kept");
      issue(0, 4'd11, 0, {pat(0)[31:24], pat(11)[23:0]}, 1'b0, "R8 other member chunk 3 kept");
      settle();

      low_pwr = 1'b0;
      issue(0, 4'd0,  0, {pat(0)[31:8], WV[7:0]}, 1'b0, "R8 spare line only owned chunk R7");
      issue(0, 4'd9,  0, WV, 1'b0, "R8 data line holds full word");
      issue(0, 4'd15, 0, pat(15), 1'b0, "R2 disabled line usable in bypass");
      issue(0, 4'd10, 0, pat(10), 1'b0, "R2 spare line usable in bypass");
      settle();

      done = 1;
      summary();
      $finish;
   end
endmodule